// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link: a shift clock, a data output and a data input. Sending and receiving happen in the same transfer on the same shift clock, least significant bit first. Each output bit is presented on a falling edge of the shift clock. Each input bit is captured on a rising edge and enters at the top of an 8-bit shift register. After eight bits the register holds the received byte, and the byte that was loaded has been sent out.

The shift clock has two sources. In internal mode the port makes the clock itself by dividing a one-cycle instruction tick, at one of two rates. It drives exactly eight low pulses on `sck_out` and then lets the line rest high. In external mode a link partner supplies the clock on `sck_in`. That input passes through a synchronizer, and its edges are found in the system clock domain. The CPU side writes the register as a low nibble and a high nibble in one load, and reads both halves at all times. Completion is reported by a one-cycle pulse and by a sticky flag.

The controller has four states. `ST_IDLE` waits for `start`. `ST_INT_LOW` and `ST_INT_HIGH` form the two halves of each internally generated clock period. `ST_EXT_RUN` follows the synchronized external clock. The transitions are as follows. Start goes from idle to `ST_INT_LOW` when the internal source is selected, and to `ST_EXT_RUN` otherwise. When a low half-period ends, the state moves to `ST_INT_HIGH`, or back to idle after the eighth bit. When a high half-period ends, the state returns to `ST_INT_LOW`. In external mode, the eighth synchronized rising edge returns the state to idle.

Top module: `sio_port`

## Requirements
- R1: After reset the register reads 0x00, `flag` and `done` are 0, `sck_out` and `sdo` are 1, and `sck_oe` is 0.
- R2: While idle, `ld_en` writes `{ld_hi, ld_lo}` into the register. `rd_hi` and `rd_lo` always show bits 7..4 and 3..0, and they do not change while the port is idle unless a load is made.
- R3: `sdo` changes only at a falling shift-clock edge, and it presents the loaded byte least significant bit first.
- R4: `sdi` is captured at each rising shift-clock edge into bit 7 while the register shifts right, so that after eight bits the register equals the received byte with the first bit at bit 0.
- R5: In internal mode a start produces exactly eight low pulses on `sck_out`, and the line stays high whenever the port is idle.
- R6: `mode_in[0]` selects the rate. With 1, each half of a shift-clock period lasts 2 instruction ticks (divide by 4). With 0, each half lasts 4 ticks (divide by 8).
- R7: With `mode_in[1]`=0 (external clock), `sck_out` stays high. Shifting follows the synchronized edges of `sck_in`, and the transfer ends on the eighth rising edge.
- R8: When the eighth bit is captured, `done` pulses for one cycle and `flag` is set. `flag` then stays set until `flag_clr` or a new start clears it.
- R9: While a transfer is running, `ld_en`, `mode_wr` and `start` have no effect.
- R10: `sck_oe` equals the clock-source bit `mode_in[1]` last written by `mode_wr` while idle (1 = internal clock, driven out).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_tick | input | 1 | One-cycle instruction-clock tick |
| ld_en | input | 1 | Load both nibbles into the register |
| ld_lo | input | 4 | Low nibble to load |
| ld_hi | input | 4 | High nibble to load |
| rd_lo | output | 4 | Register bits 3..0 |
| rd_hi | output | 4 | Register bits 7..4 |
| mode_wr | input | 1 | Write the mode register |
| mode_in | input | 2 | Bit 1 clock source (1 internal), bit 0 rate (1 = divide by 4) |
| start | input | 1 | Begin a transfer |
| flag_clr | input | 1 | Clear the completion flag |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Generated shift clock, idle high |
| sck_oe | output | 1 | Shift clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| done | output | 1 | One-cycle completion pulse |
| flag | output | 1 | Sticky completion flag |

## Verification
Random byte pairs are sent and received in internal mode at both rates and in external mode. Matching the serialized output against the loaded byte shows whether the bit order and the falling-edge timing are right. Matching the read-back halves against the received byte shows whether rising-edge capture and nibble placement are right. The low half-period is measured with a tick on every cycle and with a sparse tick, which separates the divide-by-4 rate from the divide-by-8 rate and shows that the port counts ticks rather than clocks. Loads, mode writes and starts are injected in the middle of a transfer, and the flag is set and cleared around transfers, so that ignored commands can be told apart from commands that take effect.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_INT_LOW  = 2'd1,
        ST_INT_HIGH = 2'd2,
        ST_EXT_RUN  = 2'd3
    } sio_state_e;
endpackage

// File: rtl/sio_rate_div.sv
module sio_rate_div #(
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    input  logic fast,
    output logic half_done
);
    localparam int HALF_FAST = DIV_FAST / 2;
    localparam int HALF_SLOW = DIV_SLOW / 2;
    localparam int CW = $clog2(HALF_SLOW) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit     = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
    assign half_done = run && tick && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_in};
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             cnt_clr,
    input  logic             fall_stb,
    input  logic             rise_stb,
    input  logic             sdi,
    output logic [WIDTH-1:0] data,
    output logic             sdo,
    output logic             last
);
    localparam int BW = $clog2(WIDTH);

    logic [WIDTH-1:0] data_q;
    logic [BW-1:0]    bit_q;
    logic             sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= load_data;
        end else if (rise_stb) begin
            data_q <= {sdi, data_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (cnt_clr) begin
            bit_q <= '0;
        end else if (rise_stb) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b1;
        end else if (fall_stb) begin
            sdo_q <= data_q[0];
        end
    end

    assign data = data_q;
    assign sdo  = sdo_q;
    assign last = (bit_q == BW'(WIDTH - 1));
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int DIV_FAST    = 4,
    parameter int DIV_SLOW    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_tick,
    input  logic             ld_en,
    input  logic [NIB_W-1:0] ld_lo,
    input  logic [NIB_W-1:0] ld_hi,
    output logic [NIB_W-1:0] rd_lo,
    output logic [NIB_W-1:0] rd_hi,
    input  logic             mode_wr,
    input  logic [1:0]       mode_in,
    input  logic             start,
    input  logic             flag_clr,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic             sdi,
    output logic             sdo,
    output logic             done,
    output logic             flag
);
    localparam int DATA_W = 2 * NIB_W;

    sio_state_e        state_q, state_d;
    logic              int_sel_q, fast_q;
    logic              flag_q, done_q;
    logic              busy, idle;
    logic              half_done, ext_rise, ext_fall, last;
    logic              fall_stb, rise_stb, fin, div_clr, cnt_clr, div_run;
    logic [DATA_W-1:0] data;

    assign idle    = (state_q == ST_IDLE);
    assign busy    = !idle;
    assign div_run = (state_q == ST_INT_LOW) || (state_q == ST_INT_HIGH);

    sio_rate_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(div_clr), .run(div_run),
        .tick(instr_tick), .fast(fast_q), .half_done(half_done)
    );

    sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sck_in),
        .rise(ext_rise), .fall(ext_fall)
    );

    sio_shifter #(.WIDTH(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(ld_en && idle),
        .load_data({ld_hi, ld_lo}), .cnt_clr(cnt_clr),
        .fall_stb(fall_stb), .rise_stb(rise_stb), .sdi(sdi),
        .data(data), .sdo(sdo), .last(last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = int_sel_q ? ST_INT_LOW : ST_EXT_RUN;
            end
            ST_INT_LOW: begin
                if (half_done) state_d = last ? ST_IDLE : ST_INT_HIGH;
            end
            ST_INT_HIGH: begin
                if (half_done) state_d = ST_INT_LOW;
            end
            ST_EXT_RUN: begin
                if (ext_rise && last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output strobes
    always_comb begin
        fall_stb = 1'b0;
        rise_stb = 1'b0;
        fin      = 1'b0;
        div_clr  = 1'b0;
        cnt_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cnt_clr  = 1'b1;
                    div_clr  = 1'b1;
                    fall_stb = int_sel_q;
                end
            end
            ST_INT_LOW: begin
                if (half_done) begin
                    rise_stb = 1'b1;
                    fin      = last;
                end
            end
            ST_INT_HIGH: begin
                fall_stb = half_done;
            end
            ST_EXT_RUN: begin
                fall_stb = ext_fall;
                if (ext_rise) begin
                    rise_stb = 1'b1;
                    fin      = last;
                end
            end
            default: ;
        endcase
    end

    // Mode register, frozen during a transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_sel_q <= 1'b0;
            fast_q    <= 1'b0;
        end else if (mode_wr && idle) begin
            int_sel_q <= mode_in[1];
            fast_q    <= mode_in[0];
        end
    end

    // Completion pulse and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (fin) begin
                flag_q <= 1'b1;
            end else if (flag_clr || (start && idle)) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign sck_out = (state_q != ST_INT_LOW);
    assign sck_oe  = int_sel_q;
    assign rd_lo   = data[NIB_W-1:0];
    assign rd_hi   = data[DATA_W-1:NIB_W];
    assign done    = done_q;
    assign flag    = flag_q;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       ld_en,
    input logic [7:0] rd_all,
    input logic       sck_out,
    input logic       sck_oe,
    input logic       sdo,
    input logic       done,
    input logic       flag
);
    p_idle_sck_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out);

    p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !$stable(sdo)) |-> $fell(sck_out));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ld_en) |=> $stable(rd_all));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_flag_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flag);

    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sck_oe));

    p_ext_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |-> sck_out);
endmodule

bind sio_port sio_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ld_en(ld_en),
    .rd_all({rd_hi, rd_lo}), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdo(sdo), .done(done), .flag(flag)
);

// File: tb/sio_port_test.sv
module sio_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_tick = 1'b0;
    logic       ld_en = 1'b0;
    logic [3:0] ld_lo = '0, ld_hi = '0;
    logic [3:0] rd_lo, rd_hi;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_in = '0;
    logic       start = 1'b0, flag_clr = 1'b0;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe, sdi = 1'b0, sdo, done, flag;

    int checks = 0, errors = 0;
    int tick_every = 1, tick_ph = 0;
    int done_total = 0, ext_low_seen = 0;

    sio_port uut (
        .clk(clk), .rst_n(rst_n), .instr_tick(instr_tick),
        .ld_en(ld_en), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .mode_wr(mode_wr), .mode_in(mode_in),
        .start(start), .flag_clr(flag_clr), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
        .done(done), .flag(flag)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tick_ph = (tick_ph + 1 >= tick_every) ? 0 : tick_ph + 1;
        instr_tick = (tick_ph == 0);
        if (rst_n && done) done_total = done_total + 1;
        if (rst_n && !sck_oe && !sck_out) ext_low_seen = ext_low_seen + 1;
    end

    initial begin
        #1_000_000;
        errors = errors + 1;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int half_len(input bit fast, input int te);
        return (fast ? 2 : 4) * te;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] v);
        ld_lo = v[3:0]; ld_hi = v[7:4]; ld_en = 1'b1;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_in = m; mode_wr = 1'b1;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic run_int(input bit fast, input int te, input logic [7:0] tx,
                           input logic [7:0] rx, input bit inject);
        logic [7:0] got = '0;
        int falls = 0, rises = 0, lowlen = 0, bad_len = 0, cyc = 0, extra = 0;
        int d0;
        bit prev = 1'b1;
        tick_every = te;
        load(tx);
        set_mode({1'b1, fast});
        d0 = done_total;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (cyc < 4000 && extra < 30) begin
            ld_en = 1'b0; mode_wr = 1'b0; start = 1'b0;
            if (prev && !sck_out) begin
                falls = falls + 1;
                if (falls <= 8) begin
                    got[falls-1] = sdo;
                    sdi = rx[falls-1];
                end
                lowlen = 1;
                if (inject && falls == 3) begin
                    ld_lo = 4'h5; ld_hi = 4'hA; ld_en = 1'b1;
                    mode_in = 2'b00; mode_wr = 1'b1; start = 1'b1;
                end
            end else if (!sck_out) begin
                lowlen = lowlen + 1;
            end else if (!prev && sck_out) begin
                rises = rises + 1;
                if ((te == 1 || rises > 1) && lowlen != half_len(fast, te))
                    bad_len = bad_len + 1;
            end
            if (rises >= 8) extra = extra + 1;
            prev = sck_out;
            cyc = cyc + 1;
            @(negedge clk);
        end
        chk(falls == 8, "R5 pulse count", falls, 8);
        chk(bad_len == 0, "R6 low half-period", bad_len, 0);
        chk(got == tx, "R3 serialized output", got, tx);
        chk({rd_hi, rd_lo} == rx, "R4 received byte", {rd_hi, rd_lo}, rx);
        chk(done_total - d0 == 1, "R8 done pulse count", done_total - d0, 1);
        chk(flag == 1'b1, "R8 flag set", flag, 1);
        chk(sck_oe == 1'b1, "R10 oe internal", sck_oe, 1);
        if (inject) begin
            chk(sck_oe == 1'b1 && got == tx, "R9 mode write ignored", sck_oe, 1);
            chk({rd_hi, rd_lo} == rx, "R9 load ignored", {rd_hi, rd_lo}, rx);
        end
    endtask

    task automatic run_ext(input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] got = '0;
        int d0, l0;
        load(tx);
        set_mode(2'b01);
        chk(sck_oe == 1'b0, "R10 oe external", sck_oe, 0);
        d0 = done_total; l0 = ext_low_seen;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(flag == 1'b0, "R8 start clears flag", flag, 0);
        for (int b = 0; b < 8; b++) begin
            sck_in = 1'b0; sdi = rx[b];
            repeat (5) @(negedge clk);
            got[b] = sdo;
            sck_in = 1'b1;
            repeat (5) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(got == tx, "R7 external serialized output", got, tx);
        chk({rd_hi, rd_lo} == rx, "R7 external received byte", {rd_hi, rd_lo}, rx);
        chk(ext_low_seen == l0, "R7 sck_out quiet", ext_low_seen - l0, 0);
        chk(done_total - d0 == 1 && flag, "R8 external completion", done_total - d0, 1);
    endtask

    initial begin
        logic [7:0] a, b;
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        chk({rd_hi, rd_lo} == 8'h00, "R1 reset data", {rd_hi, rd_lo}, 0);
        chk(!flag && !done, "R1 reset flag", {flag, done}, 0);
        chk(sck_out && sdo && !sck_oe, "R1 reset pins", {sck_out, sdo, sck_oe}, 3'b110);
        rst_n = 1'b1;
        @(negedge clk);

        load(8'hC3);
        chk(rd_lo == 4'h3 && rd_hi == 4'hC, "R2 nibble load", {rd_hi, rd_lo}, 8'hC3);
        repeat (3) @(negedge clk);
        chk({rd_hi, rd_lo} == 8'hC3, "R2 idle hold", {rd_hi, rd_lo}, 8'hC3);

        run_int(1'b1, 1, 8'h01, 8'h80, 1'b0);
        run_int(1'b0, 1, 8'hA5, 8'h3C, 1'b0);
        for (int i = 0; i < 6; i++) begin
            a = 8'($urandom); b = 8'($urandom);
            run_int(1'($urandom), 1, a, b, 1'b0);
        end
        run_int(1'b0, 3, 8'hFE, 8'h7F, 1'b0);
        run_int(1'b1, 1, 8'h96, 8'h69, 1'b1);

        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(flag == 1'b0, "R8 flag_clr", flag, 0);
        run_int(1'b1, 1, 8'h55, 8'hAA, 1'b0);

        run_ext(8'h4B, 8'hD2);
        for (int i = 0; i < 3; i++) begin
            a = 8'($urandom); b = 8'($urandom);
            run_ext(a, b);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule